// File: doc/BRIEF.md
# Calendar Clock Core with Maskable Interrupts

This block keeps time of day and a full calendar: seconds, minutes, hours, day of week, date, month, two-digit year and century, so any year from 0000 to 9999 can be held. It is advanced by a clock-enable pulse at 32.768 kHz (`osc_tick`, one `clk` cycle wide per oscillator period); a prescaler of `DIV_BITS` stages turns those pulses into a once-per-second update. Time is stored in binary inside the block. A format bit in the control register decides whether values written and read at the register port are binary or packed BCD.

Three interrupt sources are provided: a periodic interrupt taken from a prescaler tap, an alarm that fires when time of day and day of month match four alarm registers, and an update interrupt raised after every one-second update. Each source has a flag and an enable. The flags combine with their enables into a summary bit that drives `irq_out`. Reading the flag register returns the flags and clears them. The system reset `rst` clears the enables and the flags but does not disturb the time, which keeps counting. While `rst` is high, the register port is closed and `irq_drive` is low so that the pad can float.

Register map (4-bit `addr`): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hours, 11 alarm date, 12 control, 13 flags. Other addresses read as zero and ignore writes.

Top module: `rtc_core`

## Requirements
- R1: In binary format (control bit 7 = 1), a value written to any of addresses 0 to 11 reads back unchanged from the same address.
- R2: In BCD format (control bit 7 = 0), writes to addresses 0 to 11 are taken as packed BCD (tens in bits 7:4, units in bits 3:0) and reads return packed BCD. Switching the format changes only how the stored value is shown.
- R3: Seconds advance once every 2^DIV_BITS `osc_tick` pulses. A write to the seconds register restarts the sub-second count, so the first advance after that write comes on the 2^DIV_BITS-th pulse.
- R4: Seconds 59 carry into minutes, minutes 59 into hours, and hours 23 into the next day. The next day moves day of week from 7 to 1 (else +1) and advances the date. Month 12 wraps to 1 and carries into the year, year 99 wraps to 0 and carries into the century, and century 99 wraps to 0.
- R5: A date rolls over after day 30 in months 4, 6, 9 and 11, after day 31 in other months, and after day 29 in February when the year register is a multiple of 4 (else after day 28). The century never changes the leap decision, because 100 is a multiple of 4.
- R6: The update flag (flags bit 2) is set after every one-second update.
- R7: The alarm flag (flags bit 1) is set after an update when seconds, minutes, hours and date all equal alarm registers 8, 9, 10 and 11.
- R8: For rate code r = control bits 3:0 in the range 3 to 15, the periodic flag (flags bit 0) is set every 2^(r-1) pulses, counted from the last seconds write. Codes that ask for a period longer than one second give one per second. Codes 0, 1 and 2 never set it.
- R9: Flags are set whatever the enables are. `irq_out` and flags bit 7 are high exactly when a set flag has its enable set. The enables are control bit 4 (periodic), bit 5 (alarm) and bit 6 (update).
- R10: A read of address 13 returns the flags and clears them. An event in the same cycle as the read is kept.
- R11: `rst` clears the three enables and all flags, and leaves time, alarm, rate and format untouched. Time keeps counting during reset. While `rst` is high, writes are ignored, `rdata` is 0 and `irq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| osc_tick | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at address 13) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_out | output | 1 | Interrupt request level |
| irq_drive | output | 1 | Output enable for the interrupt pad, low during reset |

## Verification
The calendar is first set to hand-picked edges and advanced by one second: end of year and end of century, 9999 wrapping to 0000, February in leap and common years (including a century year), and a 30-day month. Each case separates one rollover rule from the others. Random legal dates are then biased toward end-of-month and end-of-day instants and advanced one to three seconds in randomly chosen binary or BCD format. Every field is compared against a bench calendar model, which shows whether a carry error is tied to the format conversion or to the counting. Periodic rates are probed one pulse before and at their expected period, with both the capped and the disabled codes. A flag read placed on the exact cycle of a periodic event shows whether the clear and the set are ordered correctly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NFLD = 8;
    localparam int NALM = 4;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;
    localparam int F_CENT = 7;

    typedef logic [6:0] fld_t;
    typedef fld_t [NFLD-1:0] tm_t;
    typedef fld_t [NALM-1:0] alm_t;

    typedef enum logic [3:0] {
        RA_SEC   = 4'd0,
        RA_CENT  = 4'd7,
        RA_ASEC  = 4'd8,
        RA_ADATE = 4'd11,
        RA_CTRL  = 4'd12,
        RA_FLAGS = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic       binary;
        logic       uie;
        logic       aie;
        logic       pie;
        logic [3:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic uf;
        logic af;
        logic pf;
    } flags_t;

    function automatic logic [7:0] to_bcd(fld_t v);
        logic [7:0] w;
        w = {1'b0, v};
        return ((w / 8'd10) << 4) | (w % 8'd10);
    endfunction

    function automatic fld_t from_bcd(logic [7:0] b);
        return fld_t'({4'b0, b[7:4]} * 8'd10 + {4'b0, b[3:0]});
    endfunction

    function automatic fld_t month_len(fld_t mon, fld_t year);
        if (mon == 7'd2)
            return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
        else if (mon == 7'd4 || mon == 7'd6 || mon == 7'd9 || mon == 7'd11)
            return 7'd30;
        else
            return 7'd31;
    endfunction

    function automatic tm_t tm_step(tm_t t);
        tm_t  n;
        logic c;
        fld_t mlen;
        n    = t;
        mlen = month_len(t[F_MON], t[F_YEAR]);
        c    = t[F_SEC] >= 7'd59;
        n[F_SEC] = c ? 7'd0 : t[F_SEC] + 7'd1;
        if (c) begin
            c = t[F_MIN] >= 7'd59;
            n[F_MIN] = c ? 7'd0 : t[F_MIN] + 7'd1;
        end
        if (c) begin
            c = t[F_HOUR] >= 7'd23;
            n[F_HOUR] = c ? 7'd0 : t[F_HOUR] + 7'd1;
        end
        if (c) begin
            n[F_DOW]  = (t[F_DOW] >= 7'd7) ? 7'd1 : t[F_DOW] + 7'd1;
            c = t[F_DATE] >= mlen;
            n[F_DATE] = c ? 7'd1 : t[F_DATE] + 7'd1;
        end
        if (c) begin
            c = t[F_MON] >= 7'd12;
            n[F_MON] = c ? 7'd1 : t[F_MON] + 7'd1;
        end
        if (c) begin
            c = t[F_YEAR] >= 7'd99;
            n[F_YEAR] = c ? 7'd0 : t[F_YEAR] + 7'd1;
        end
        if (c)
            n[F_CENT] = (t[F_CENT] >= 7'd99) ? 7'd0 : t[F_CENT] + 7'd1;
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       restart,
    input  logic [3:0] rate,
    output logic       sec_tick,
    output logic       per_hit
);

    logic [DIV_BITS-1:0] cnt;
    logic [DIV_BITS-1:0] mask;

    // sub-second chain is battery-side state: no system reset
    always_ff @(posedge clk) begin
        if (restart)
            cnt <= '0;
        else if (osc_tick)
            cnt <= cnt + 1'b1;
    end

    // tap mask: low (rate-1) bits, saturating at the full chain
    always_comb begin
        for (int i = 0; i < DIV_BITS; i++)
            mask[i] = (i < (int'(rate) - 1));
    end

    assign sec_tick = osc_tick && !restart && (&cnt);
    assign per_hit  = osc_tick && !restart && (rate >= 4'd3) && ((cnt & mask) == mask);

    // R3: two second updates are never adjacent
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    // R8: every second boundary is also a periodic boundary for enabled codes
    a_r8_second_aligned: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && rate >= 4'd3) |-> per_hit);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       we,
    input  logic [3:0] waddr,
    input  fld_t       wval,
    output tm_t        tm,
    output alm_t       alm,
    output logic       match
);

    // time and alarm survive system reset
    always_ff @(posedge clk) begin
        if (sec_tick)
            tm <= tm_step(tm);
        if (we && !waddr[3])
            tm[waddr[2:0]] <= wval;
        if (we && waddr[3:2] == 2'b10)
            alm[waddr[1:0]] <= wval;
    end

    assign match = (tm[F_SEC]  == alm[0]) && (tm[F_MIN]  == alm[1]) &&
                   (tm[F_HOUR] == alm[2]) && (tm[F_DATE] == alm[3]);

    // R4: an update either increments seconds or wraps them to zero
    a_r4_sec_step: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !we) |=> (tm[F_SEC] == 7'd0 || tm[F_SEC] == $past(tm[F_SEC]) + 7'd1));

    // R4: seconds 59 carries into minutes
    a_r4_min_carry: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !we && tm[F_SEC] == 7'd59 && tm[F_MIN] < 7'd59)
        |=> tm[F_MIN] == $past(tm[F_MIN]) + 7'd1);

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] wdata,
    input  logic       flag_rd,
    input  logic       per_hit,
    input  logic       sec_tick,
    input  logic       match,
    output ctrl_t      ctrl,
    output flags_t     flags,
    output logic       irq
);

    logic   upd_q;
    flags_t sets;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.pie <= 1'b0;
            ctrl.aie <= 1'b0;
            ctrl.uie <= 1'b0;
        end else if (ctrl_we) begin
            ctrl <= ctrl_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            upd_q <= 1'b0;
        else
            upd_q <= sec_tick;
    end

    assign sets = '{uf: upd_q, af: upd_q && match, pf: per_hit};

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flag_rd ? flags_t'(3'b000) : flags) | sets;
    end

    assign irq = (flags.pf && ctrl.pie) || (flags.af && ctrl.aie) || (flags.uf && ctrl.uie);

    // R6: update flag follows each second update
    a_r6_update_flag: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> flags.uf);

    // R7: alarm flag follows a matching update
    a_r7_alarm_flag: assert property (@(posedge clk) disable iff (rst)
        (upd_q && match) |=> flags.af);

    // R10: a read with no concurrent event leaves all flags clear
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !upd_q && !per_hit) |=> flags == '0);

    // R11: leaving reset, flags and enables are clear
    a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags == '0 && !ctrl.pie && !ctrl.aie && !ctrl.uie));

    // R9: no request without some enable
    a_r9_masked: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.pie || ctrl.aie || ctrl.uie));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_out,
    output logic       irq_drive
);

    logic   wr_ok, rd_ok;
    logic   sec_tick, per_hit, match;
    logic   cal_we, ctrl_we, flag_rd, restart;
    fld_t   wval;
    tm_t    tm;
    alm_t   alm;
    ctrl_t  ctrl;
    flags_t flags;

    assign wr_ok   = wr_en && !rst;
    assign rd_ok   = rd_en && !rst;
    assign cal_we  = wr_ok && (addr <= RA_ADATE);
    assign restart = wr_ok && (addr == RA_SEC);
    assign ctrl_we = wr_ok && (addr == RA_CTRL);
    assign flag_rd = rd_ok && (addr == RA_FLAGS);
    assign wval    = ctrl.binary ? wdata[6:0] : from_bcd(wdata);

    rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .restart  (restart),
        .rate     (ctrl.rate),
        .sec_tick (sec_tick),
        .per_hit  (per_hit)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .we       (cal_we),
        .waddr    (addr),
        .wval     (wval),
        .tm       (tm),
        .alm      (alm),
        .match    (match)
    );

    rtc_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .wdata    (wdata),
        .flag_rd  (flag_rd),
        .per_hit  (per_hit),
        .sec_tick (sec_tick),
        .match    (match),
        .ctrl     (ctrl),
        .flags    (flags),
        .irq      (irq_out)
    );

    function automatic logic [7:0] show(fld_t v);
        return ctrl.binary ? {1'b0, v} : to_bcd(v);
    endfunction

    always_comb begin
        rdata = 8'h00;
        if (!rst) begin
            if (addr <= RA_CENT)
                rdata = show(tm[addr[2:0]]);
            else if (addr <= RA_ADATE)
                rdata = show(alm[addr[1:0]]);
            else if (addr == RA_CTRL)
                rdata = ctrl;
            else if (addr == RA_FLAGS)
                rdata = {irq_out, 4'b0000, flags};
        end
    end

    assign irq_drive = !rst;

endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;

    localparam int DIVB = 6;
    localparam int SEC  = 1 << DIVB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_out, irq_drive;

    int  total = 0;
    int  fails = 0;
    bit  done  = 0;
    bit  bmode = 1;
    int  mt[8];

    always #10 clk = ~clk;

    rtc_core #(.DIV_BITS(DIVB)) i_rtc_core (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .irq_drive(irq_drive)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc(int v);
        return bmode ? 8'(v) : bcd(v);
    endfunction

    function automatic int mdays(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic step_model();
        mt[0] += 1; if (mt[0] < 60) return; mt[0] = 0;
        mt[1] += 1; if (mt[1] < 60) return; mt[1] = 0;
        mt[2] += 1; if (mt[2] < 24) return; mt[2] = 0;
        mt[3] = (mt[3] % 7) + 1;
        mt[4] += 1; if (mt[4] <= mdays(mt[5], mt[6])) return; mt[4] = 1;
        mt[5] += 1; if (mt[5] <= 12) return; mt[5] = 1;
        mt[6] += 1; if (mt[6] < 100) return; mt[6] = 0;
        mt[7] = (mt[7] + 1) % 100;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk); addr = 4'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] d);
        @(negedge clk); addr = 4'(a); rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(int n);
        @(negedge clk); osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic set_ctrl(bit bin, bit uie, bit aie, bit pie, int rate);
        bmode = bin;
        wr(12, {bin, uie, aie, pie, 4'(rate)});
    endtask

    task automatic load(int s, int mi, int h, int dw, int dt, int mo, int y, int c);
        mt = '{s, mi, h, dw, dt, mo, y, c};
        for (int i = 0; i < 8; i++) wr(i, enc(mt[i]));
    endtask

    task automatic compare_all(string req);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            chk(d == enc(mt[i]), req, d, enc(mt[i]));
        end
    endtask

    task automatic one_second_case(string req);
        ticks(SEC);
        step_model();
        compare_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20517));

        // R11: reset state at the ports
        repeat (3) @(negedge clk);
        #1 chk(irq_drive == 1'b0, "R11 drive off in reset", irq_drive, 0);
        rd(13, d);
        chk(d == 8'h00, "R11 rdata zero in reset", d, 0);
        @(negedge clk); rst = 1'b0;
        set_ctrl(1, 0, 0, 0, 0);
        rd(12, d);
        chk(d == 8'h80, "R11 control after reset", d, 8'h80);
        rd(13, d);
        chk(d == 8'h00, "R11 flags after reset", d, 0);

        // R1: binary write and read-back
        load(33, 44, 5, 3, 17, 6, 42, 20);
        compare_all("R1 time readback");
        wr(8, 8'd7); wr(11, 8'd28);
        rd(8, d);  chk(d == 8'd7,  "R1 alarm sec readback", d, 7);
        rd(11, d); chk(d == 8'd28, "R1 alarm date readback", d, 28);

        // R2: BCD encoding
        set_ctrl(0, 0, 0, 0, 0);
        wr(0, 8'h59);
        rd(0, d); chk(d == 8'h59, "R2 bcd seconds", d, 8'h59);
        rd(6, d); chk(d == 8'h42, "R2 bcd year view", d, 8'h42);
        set_ctrl(1, 0, 0, 0, 0);
        rd(0, d); chk(d == 8'd59, "R2 binary view of bcd write", d, 59);

        // R3: seconds cadence and restart on write
        wr(0, 8'd10);
        ticks(SEC - 1);
        rd(0, d); chk(d == 8'd10, "R3 no advance before period", d, 10);
        ticks(1);
        rd(0, d); chk(d == 8'd11, "R3 advance at period", d, 11);

        // R4: carry chains
        load(59, 59, 23, 7, 31, 12, 99, 20);
        one_second_case("R4 century carry");
        rd(7, d); chk(d == 8'd21, "R4 century value", d, 21);
        rd(3, d); chk(d == 8'd1, "R4 weekday wrap", d, 1);
        load(59, 59, 23, 4, 31, 12, 99, 99);
        one_second_case("R4 year 9999 wrap");
        set_ctrl(0, 0, 0, 0, 0);
        load(59, 59, 9, 2, 14, 3, 5, 19);
        one_second_case("R4 bcd hour carry");
        set_ctrl(1, 0, 0, 0, 0);

        // R5: month lengths and leap years
        load(59, 59, 23, 1, 28, 2, 24, 20);
        one_second_case("R5 leap Feb 28");
        rd(4, d); chk(d == 8'd29, "R5 leap gives 29", d, 29);
        load(59, 59, 23, 1, 28, 2, 23, 20);
        one_second_case("R5 common Feb 28");
        rd(5, d); chk(d == 8'd3, "R5 common goes to March", d, 3);
        load(59, 59, 23, 1, 28, 2, 0, 21);
        one_second_case("R5 century year Feb 28");
        load(59, 59, 23, 1, 29, 2, 0, 21);
        one_second_case("R5 Feb 29 to March");
        load(59, 59, 23, 1, 30, 4, 10, 20);
        one_second_case("R5 April 30");
        load(59, 59, 23, 1, 30, 1, 10, 20);
        one_second_case("R5 January 30");

        // R6 / R10: update flag and read clear
        load(0, 0, 0, 1, 1, 1, 0, 20);
        rd(13, d);
        ticks(SEC); repeat (2) @(negedge clk);
        rd(13, d); chk(d[2] == 1'b1, "R6 update flag set", d, 8'h04);
        chk(d[7] == 1'b0, "R9 no summary without enable", d, 8'h04);
        rd(13, d); chk(d == 8'h00, "R10 read cleared flags", d, 0);

        // R7: alarm match and mismatch
        load(9, 0, 12, 1, 5, 1, 0, 20);
        wr(8, 8'd10); wr(9, 8'd0); wr(10, 8'd12); wr(11, 8'd5);
        rd(13, d);
        ticks(SEC); repeat (2) @(negedge clk);
        rd(13, d); chk(d[1] == 1'b1, "R7 alarm hit", d, 8'h06);
        wr(11, 8'd6); wr(0, 8'd9);
        rd(13, d);
        ticks(SEC); repeat (2) @(negedge clk);
        rd(13, d); chk(d[1:0] == 2'b00 && d[2], "R7 date mismatch no alarm", d, 8'h04);

        // R8: periodic rates
        foreach (d[i]) ;
        begin
            int rates[4] = '{3, 5, 12, 7};
            for (int k = 0; k < 4; k++) begin
                int per;
                per = 1 << (rates[k] - 1);
                if (per > SEC) per = SEC;
                set_ctrl(1, 0, 0, 0, rates[k]);
                wr(0, 8'd0);
                rd(13, d);
                ticks(per - 1); @(negedge clk);
                rd(13, d); chk(d[0] == 1'b0, "R8 periodic early", d, 0);
                ticks(1); @(negedge clk);
                rd(13, d); chk(d[0] == 1'b1, "R8 periodic on time", d, 1);
            end
            for (int k = 0; k < 3; k++) begin
                set_ctrl(1, 0, 0, 0, k);
                wr(0, 8'd0);
                rd(13, d);
                ticks(2 * SEC - 10); @(negedge clk);
                rd(13, d); chk(d[0] == 1'b0, "R8 low code never fires", d, 0);
            end
        end

        // R9: enables drive irq_out
        set_ctrl(1, 1, 0, 0, 0);
        wr(0, 8'd0);
        rd(13, d);
        ticks(SEC); repeat (2) @(negedge clk);
        #1 chk(irq_out == 1'b1, "R9 update enable raises irq", irq_out, 1);
        rd(13, d); chk(d[7] == 1'b1, "R9 summary bit", d, 8'h84);
        #1 chk(irq_out == 1'b0, "R9 irq drops after clear", irq_out, 0);
        set_ctrl(1, 0, 0, 1, 3);
        wr(0, 8'd0);
        rd(13, d);
        ticks(4); @(negedge clk);
        #1 chk(irq_out == 1'b1, "R9 periodic enable raises irq", irq_out, 1);

        // R10: read in the same cycle as a periodic event keeps it
        set_ctrl(1, 0, 0, 0, 3);
        wr(0, 8'd0);
        rd(13, d);
        ticks(3);
        @(negedge clk); osc_tick = 1'b1; addr = 4'd13; rd_en = 1'b1;
        @(negedge clk); osc_tick = 1'b0; rd_en = 1'b0;
        rd(13, d); chk(d[0] == 1'b1, "R10 concurrent event kept", d, 1);

        // R11: reset mid-run
        set_ctrl(1, 1, 1, 1, 5);
        load(20, 30, 8, 2, 9, 9, 30, 20);
        @(negedge clk); rst = 1'b1;
        ticks(2 * SEC);
        wr(0, 8'd3);
        #1 chk(irq_drive == 1'b0, "R11 drive off during reset", irq_drive, 0);
        rd(0, d); chk(d == 8'h00, "R11 rdata zero during reset", d, 0);
        @(negedge clk); rst = 1'b0;
        step_model(); step_model();
        compare_all("R11 time kept counting");
        rd(12, d); chk(d == 8'h85, "R11 enables cleared rate kept", d, 8'h85);
        rd(13, d); chk(d == 8'h00, "R11 flags cleared", d, 0);

        // random calendar walk, R4 R5 R2
        for (int it = 0; it < 24; it++) begin
            int mo, y, n;
            mo = $urandom_range(1, 12);
            y  = $urandom_range(0, 99);
            set_ctrl($urandom_range(0, 1), 0, 0, 0, 0);
            load($urandom_range(56, 59), ($urandom_range(0, 1) != 0) ? 59 : $urandom_range(0, 59),
                 ($urandom_range(0, 1) != 0) ? 23 : $urandom_range(0, 23), $urandom_range(1, 7),
                 ($urandom_range(0, 1) != 0) ? mdays(mo, y) : $urandom_range(1, mdays(mo, y)),
                 mo, y, $urandom_range(0, 99));
            n = $urandom_range(1, 3);
            ticks(n * SEC);
            for (int s = 0; s < n; s++) step_model();
            compare_all("R4 R5 random walk");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule